// File: doc/BRIEF.md
# Differential Escalation Link Sender

This block is the transmitting end of an escalation link. It drives a complementary forward wire pair toward a remote receiver. The same pair carries two kinds of traffic. A standing escalation holds the pair in its active state. A liveness ping sends a single-cycle pulse on the pair.

After a ping pulse, the receiver must answer on a complementary return pair with an alternating pattern. The sender checks that pattern one cycle at a time. If the whole pattern arrives intact, the sender acknowledges the ping. A return pair that stops being complementary, or that breaks the expected pattern, raises an integrity flag instead.

Escalation always wins over a ping. A ping still in flight is dropped without acknowledge when an escalation arrives. A receiver that sees a broken forward pair signals it by answering with a non-complementary return pair, and the sender reports that as an integrity failure while it keeps escalating.

Top module: `esc_diff_sender`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, fwd_p is 0, fwd_n is 1, and ping_ack and integ_fail are both 0.
- R2: After reset, fwd_n is always the inverse of fwd_p.
- R3: When esc_req is sampled high at a clock edge, fwd_p=1 and fwd_n=0 in the following cycle. This holds for as long as esc_req stays high. The pair returns to idle (fwd_p=0, fwd_n=1) in the cycle after esc_req is sampled low with ping_req low.
- R4: When ping_req is sampled high while the link is idle and esc_req is low, fwd_p=1/fwd_n=0 for exactly one cycle, and the pair then returns to idle.
- R5: For RSP_CYC cycles (default 3) after the ping pulse, the return pair must alternate {rsp_p,rsp_n} = 10, 01, 10, and so on. If every cycle matches, ping_ack is high for exactly one cycle, namely the cycle after the last check cycle.
- R6: In any cycle where the link is escalating or a ping is in progress, rsp_p equal to rsp_n makes integ_fail high in the next cycle. The flag is high for one cycle per failing cycle.
- R7: A complementary return pair with the wrong phase during a ping check raises integ_fail in the next cycle and abandons the ping without ping_ack.
- R8: An escalation answered with complementary return values, and a ping answered with the correct pattern, never raise integ_fail.
- R9: esc_req sampled high during a ping starts escalation in the next cycle, and that ping produces no ping_ack.
- R10: The return pair is ignored while the link is idle: no value on it raises integ_fail.
- R11: An integrity failure during escalation does not stop the escalation; fwd_p stays 1 while esc_req is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_req | input | 1 | Escalation request, level sensitive |
| ping_req | input | 1 | Ping request, taken when the link is idle |
| rsp_p | input | 1 | Return pair, positive wire |
| rsp_n | input | 1 | Return pair, negative wire |
| ping_ack | output | 1 | One-cycle pulse when a ping handshake completes cleanly |
| integ_fail | output | 1 | Integrity or handshake failure, one cycle per failing cycle |
| fwd_p | output | 1 | Forward pair, positive wire |
| fwd_n | output | 1 | Forward pair, negative wire |

## Verification
The assertions check the following on every cycle:
- The forward pair stays complementary.
- The acknowledge is a single-cycle pulse.
- A request held high drives the pair active on the next cycle.
- A split return pair during activity is always flagged, and nothing is flagged while idle.
- An escalation arriving mid-ping takes over and suppresses the acknowledge.

Only the bench's scenarios can show that the alternating answer pattern is matched in the right phase, and in which cycle the acknowledge or the failure lands. They also show that a failing escalation keeps driving and that reset clears the link mid-escalation.

// File: rtl/esc_link_pkg.sv
package esc_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ESC   = 2'd1,
    ST_PSEND = 2'd2,
    ST_PCHK  = 2'd3
  } link_st_e;

endpackage

// File: rtl/esc_rsp_check.sv
module esc_rsp_check (
  input  logic chk_on,
  input  logic phase_on,
  input  logic exp_p,
  input  logic rsp_p,
  input  logic rsp_n,
  output logic bad
);

  logic split;
  logic wrong_phase;

  always_comb begin
    split       = (rsp_p == rsp_n);
    wrong_phase = phase_on && (rsp_p != exp_p);
    bad         = chk_on && (split || wrong_phase);
  end

endmodule

// File: rtl/esc_fwd_pair.sv
module esc_fwd_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_on,
  output logic fwd_p,
  output logic fwd_n
);

  logic p_q;
  logic n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      n_q <= 1'b1;
    end else begin
      p_q <= drive_on;
      n_q <= ~drive_on;
    end
  end

  assign fwd_p = p_q;
  assign fwd_n = n_q;

  // R2
  fwd_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_q != n_q);

endmodule

// File: rtl/esc_link_fsm.sv
module esc_link_fsm
  import esc_link_pkg::*;
#(
  parameter int unsigned RSP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esc_req,
  input  logic ping_req,
  input  logic rsp_p,
  input  logic rsp_n,
  output logic drive_on,
  output logic ping_ack,
  output logic integ_fail
);

  localparam int unsigned CW = (RSP_CYC > 1) ? $clog2(RSP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(RSP_CYC - 1);

  link_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic ack_q, ack_d;
  logic fail_q;
  logic bad;
  logic chk_on, phase_on, exp_p;

  assign chk_on   = (st_q != ST_IDLE);
  assign phase_on = (st_q == ST_PCHK);
  assign exp_p    = ~cnt_q[0];

  esc_rsp_check u_chk (
    .chk_on   (chk_on),
    .phase_on (phase_on),
    .exp_p    (exp_p),
    .rsp_p    (rsp_p),
    .rsp_n    (rsp_n),
    .bad      (bad)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ack_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (esc_req)       st_d = ST_ESC;
        else if (ping_req) st_d = ST_PSEND;
      end
      ST_ESC: begin
        if (!esc_req) st_d = ST_IDLE;
      end
      ST_PSEND: begin
        if (esc_req) begin
          st_d = ST_ESC;
        end else begin
          st_d   = ST_PCHK;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_PCHK: begin
        if (esc_req) begin
          st_d = ST_ESC;
        end else if (bad) begin
          st_d = ST_IDLE;
        end else if (cnt_q == LAST) begin
          st_d  = ST_IDLE;
          ack_d = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign drive_on = (st_d == ST_ESC) || (st_d == ST_PSEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d;
      fail_q <= bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ping_ack   = ack_q;
  assign integ_fail = fail_q;

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R6
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && rsp_p == rsp_n) |=> fail_q);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> !fail_q);

  // R9
  esc_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_req && (st_q == ST_PSEND || st_q == ST_PCHK)) |=> (!ack_q && st_q == ST_ESC));

endmodule

// File: rtl/esc_diff_sender.sv
module esc_diff_sender #(
  parameter int unsigned RSP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esc_req,
  input  logic ping_req,
  input  logic rsp_p,
  input  logic rsp_n,
  output logic ping_ack,
  output logic integ_fail,
  output logic fwd_p,
  output logic fwd_n
);

  logic drive_on;

  esc_link_fsm #(.RSP_CYC(RSP_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .esc_req    (esc_req),
    .ping_req   (ping_req),
    .rsp_p      (rsp_p),
    .rsp_n      (rsp_n),
    .drive_on   (drive_on),
    .ping_ack   (ping_ack),
    .integ_fail (integ_fail)
  );

  esc_fwd_pair u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_on (drive_on),
    .fwd_p    (fwd_p),
    .fwd_n    (fwd_n)
  );

  // R3
  esc_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |=> (fwd_p && !fwd_n));

  // R3
  esc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!esc_req && !ping_req) |=> !fwd_p);

endmodule

// File: tb/sim_esc_diff_sender.sv
`timescale 1ns/1ps
module sim_esc_diff_sender;

  localparam real CLK_NS = 5.0;

  logic clk, rst_n, esc_req, ping_req, rsp_p, rsp_n;
  logic ping_ack, integ_fail, fwd_p, fwd_n;
  int total = 0;
  int bad = 0;

  // [7:6] slot0 {p,n}, [5:4] slot1, [3:2] slot2, [1] expect ack, [0] expect fail
  localparam logic [7:0] PV [5] = '{
    8'b10_01_10_1_0,
    8'b11_01_10_0_1,
    8'b10_00_10_0_1,
    8'b10_01_01_0_1,
    8'b01_01_10_0_1
  };

  esc_diff_sender u0 (
    .clk(clk), .rst_n(rst_n), .esc_req(esc_req), .ping_req(ping_req),
    .rsp_p(rsp_p), .rsp_n(rsp_n), .ping_ack(ping_ack),
    .integ_fail(integ_fail), .fwd_p(fwd_p), .fwd_n(fwd_n)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack_seen, fail_seen;
    rst_n = 1'b0; esc_req = 1'b0; ping_req = 1'b0; rsp_p = 1'b0; rsp_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 fwd in reset", {fwd_p, fwd_n}, 2'b01);
    chk("R1 flags in reset", {ping_ack, integ_fail}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {fwd_p, fwd_n, ping_ack, integ_fail}, 4'b0100);

    // ping handshakes from the vector table
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ping_req = 1'b1; rsp_p = 1'b0; rsp_n = 1'b1;
      @(negedge clk);
      chk("R4 ping pulse", {fwd_p, fwd_n}, 2'b10);
      ping_req = 1'b0;
      @(negedge clk);
      chk("R4 pulse ends", {fwd_p, fwd_n}, 2'b01);
      ack_seen = 1'b0; fail_seen = 1'b0;
      rsp_p = PV[k][7]; rsp_n = PV[k][6];
      for (int s = 1; s <= 3; s++) begin
        @(negedge clk);
        ack_seen  = ack_seen | ping_ack;
        fail_seen = fail_seen | integ_fail;
        if (s < 3) begin
          rsp_p = PV[k][7-2*s]; rsp_n = PV[k][6-2*s];
        end else begin
          rsp_p = 1'b0; rsp_n = 1'b1;
        end
      end
      chk($sformatf("R5 ack vec%0d", k), ack_seen, PV[k][1]);
      chk($sformatf("R7 fail vec%0d", k), fail_seen, PV[k][0]);
      @(negedge clk);
      chk("R5 ack one cycle", ping_ack, 1'b0);
    end

    // clean escalation with toggling complementary answer
    @(negedge clk); esc_req = 1'b1; rsp_p = 1'b0; rsp_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 escalating", {fwd_p, fwd_n}, 2'b10);
      chk("R8 no fail in esc", integ_fail, 1'b0);
      chk("R2 complement", fwd_p ^ fwd_n, 1'b1);
      rsp_p = ~rsp_p; rsp_n = ~rsp_n;
    end
    esc_req = 1'b0;
    @(negedge clk);
    chk("R3 release", {fwd_p, fwd_n}, 2'b01);
    chk("R8 no fail after esc", integ_fail, 1'b0);
    rsp_p = 1'b0; rsp_n = 1'b1;

    // escalation with broken answer (forward wire stuck seen by receiver)
    @(negedge clk); esc_req = 1'b1;
    @(negedge clk); rsp_p = 1'b1; rsp_n = 1'b1;
    @(negedge clk);
    chk("R6 split flagged", integ_fail, 1'b1);
    chk("R11 still escalating", {fwd_p, fwd_n}, 2'b10);
    rsp_p = 1'b1; rsp_n = 1'b0;
    @(negedge clk);
    chk("R6 one cycle", integ_fail, 1'b0);
    esc_req = 1'b0; rsp_p = 1'b0; rsp_n = 1'b1;
    @(negedge clk);
    chk("R3 idle again", fwd_p, 1'b0);

    // escalation overtakes ping
    @(negedge clk); ping_req = 1'b1;
    @(negedge clk); ping_req = 1'b0;
    @(negedge clk); rsp_p = 1'b1; rsp_n = 1'b0; esc_req = 1'b1;
    ack_seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ack_seen = ack_seen | ping_ack;
      chk("R9 esc takes over", {fwd_p, fwd_n}, 2'b10);
      rsp_p = ~rsp_p; rsp_n = ~rsp_n;
    end
    esc_req = 1'b0; rsp_p = 1'b0; rsp_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      ack_seen = ack_seen | ping_ack;
    end
    chk("R9 no ack", ack_seen, 1'b0);

    // idle ignores return pair
    rsp_p = 1'b1; rsp_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 idle ignore", integ_fail, 1'b0);
    end
    rsp_p = 1'b0; rsp_n = 1'b0;
    @(negedge clk);
    chk("R10 idle ignore 00", integ_fail, 1'b0);
    rsp_p = 1'b0; rsp_n = 1'b1;

    // reset during escalation
    @(negedge clk); esc_req = 1'b1;
    @(negedge clk);
    chk("R3 before reset", fwd_p, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {fwd_p, fwd_n, ping_ack, integ_fail}, 4'b0100);
    @(negedge clk); esc_req = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {fwd_p, fwd_n}, 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule